// File: doc/BRIEF.md
# Cascadable LED Channel Shift-and-Latch Path

This block is the digital serial path of an eight-channel LED sink driver built to be chained device to device. Display bits arrive one at a time on a serial data line and are timed by a serial clock. A load strobe then copies the assembled byte into a display register, and that register drives the channel-on outputs while the active-low output enable is low. The serial output carries the shift-register contents on to the next device in the chain. With three devices chained, a 24-bit stream puts one byte in each device. The first byte sent ends up in the device furthest from the source.

The same chain also carries diagnostic reports. While the error-report mode input is high, a falling load edge replaces the shift-register contents with an 8-bit word from the diagnostic logic. Later serial clocks then push that report out through the chain. The analog current sinks and the fault comparators lie outside the block. The report word arrives as a digital input.

All inputs are synchronous to the system clock `clk`. Each of the serial clock and the load strobe is followed by a two-state tracker with the states LVL_LOW and LVL_HIGH. The transition LVL_LOW to LVL_HIGH marks a rising edge and LVL_HIGH to LVL_LOW marks a falling edge. In each system clock cycle, the shift stage picks one operation in priority order: OP_PLOAD (parallel report load), OP_SHIFT (rising serial clock), OP_RETIME (falling serial clock), or OP_HOLD.

Top module: `led_chain_slice`

## Requirements
- R1: While reset is active, the shift register and display register are zero, every channel output is 0 and the serial output is 0.
- R2: In the system cycle where the serial clock is first seen high, the shift register shifts up by one and takes the serial input into bit 0. After eight such clocks, the bit sent first sits in bit 7, which belongs to channel 7.
- R3: The serial output changes only in the system cycle where the serial clock is first seen low, or on a parallel load. On a falling serial clock edge it takes the current bit 7 of the shift register. A rising serial edge therefore sees the old bit 7 first, and then old bits 6 down to 0 on the following rising edges. This gives each device exactly eight bit positions in the chain.
- R4: When error-report mode is low, a rising load edge copies the shift register into the display register. Shifting alone never changes the display register.
- R5: Channel i is on (1) only when display-register bit i is 1 and the output enable is 0. Enable at 1 forces all channels to 0 in every mode.
- R6: When error-report mode is high, a falling load edge copies the error word into the shift register. In the same cycle the serial output takes error-word bit 7. The following rising serial edges then present error bits 7 down to 0 to the next device.
- R7: If a parallel load and a rising serial edge fall in the same system cycle, the load wins and the shift is dropped.
- R8: When error-report mode is high, a rising load edge leaves the display register unchanged.
- R9: When error-report mode is low, a falling load edge leaves the shift register and serial output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, sampled by clk |
| ser_din | input | 1 | Serial data in |
| load_strobe | input | 1 | Latch strobe (rise: display copy, fall: report load) |
| oe_n | input | 1 | Active-low channel enable |
| err_mode | input | 1 | Error-report mode select |
| err_word | input | CHANNELS | Diagnostic word for parallel load |
| chan_on | output | CHANNELS | Per-channel sink enable |
| ser_dout | output | 1 | Serial data out to the next device |

## Verification
Three devices are chained and given two display streams, 24'hA53C81 and 24'h0F7E33. The resulting per-device bytes show whether the bit order and the eight-position spacing per device are right. The output is read during the high phase and again after the falling edge of one pulse, which tells rising-edge retiming apart from falling-edge retiming. An error-report load shifted through all three devices shows whether reports come out most significant bit first and in the right device order. A load timed to coincide with a rising serial edge shows whether a shift is wrongly applied after the load. Loads taken in the opposite mode, together with toggling the enable, show that each edge acts only in its own mode.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pulse_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_RETIME = 2'd2,
        OP_PLOAD  = 2'd3
    } shift_op_e;

endpackage

// File: rtl/edge_tracker.sv
module edge_tracker
    import led_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        level_in,
    output edge_pulse_t pulses
);

    level_state_e state_q;
    level_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (level_in)  state_d = LVL_HIGH;
            LVL_HIGH: if (!level_in) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // Edge outputs, one per transition
    always_comb begin
        pulses = '0;
        unique case (state_q)
            LVL_LOW:  pulses.rise = level_in;
            LVL_HIGH: pulses.fall = !level_in;
            default:  pulses = '0;
        endcase
    end

endmodule

// File: rtl/shift_stage.sv
module shift_stage
    import led_chain_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             retime_en,
    input  logic             pload_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] pload_word,
    output logic [WIDTH-1:0] shift_word,
    output logic             ser_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sreg_q;
    logic             sout_q;
    shift_op_e        op;

    // Operation select: parallel load beats shift, shift beats retime
    always_comb begin
        if (pload_en) begin
            op = OP_PLOAD;
        end else if (shift_en) begin
            op = OP_SHIFT;
        end else if (retime_en) begin
            op = OP_RETIME;
        end else begin
            op = OP_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            sout_q <= 1'b0;
        end else begin
            unique case (op)
                OP_PLOAD: begin
                    sreg_q <= pload_word;
                    sout_q <= pload_word[MSB];
                end
                OP_SHIFT:  sreg_q <= {sreg_q[MSB-1:0], ser_in};
                OP_RETIME: sout_q <= sreg_q[MSB];
                OP_HOLD:   sreg_q <= sreg_q;
                default:   sreg_q <= sreg_q;
            endcase
        end
    end

    assign shift_word = sreg_q;
    assign ser_out    = sout_q;

endmodule

// File: rtl/display_latch.sv
module display_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] word_in,
    input  logic             oe_n,
    output logic [WIDTH-1:0] chan_on
);

    logic [WIDTH-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= word_in;
        end
    end

    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_gate
        assign chan_on[ch] = data_q[ch] & ~oe_n;
    end

endmodule

// File: rtl/led_chain_slice.sv
module led_chain_slice
    import led_chain_pkg::*;
#(
    parameter int CHANNELS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_din,
    input  logic                load_strobe,
    input  logic                oe_n,
    input  logic                err_mode,
    input  logic [CHANNELS-1:0] err_word,
    output logic [CHANNELS-1:0] chan_on,
    output logic                ser_dout
);

    edge_pulse_t        sclk_edge;
    edge_pulse_t        load_edge;
    logic [CHANNELS-1:0] shift_word;
    logic               report_load;
    logic               display_capture;

    edge_tracker u_sclk_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (ser_clk),
        .pulses   (sclk_edge)
    );

    edge_tracker u_load_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (load_strobe),
        .pulses   (load_edge)
    );

    assign report_load     = load_edge.fall & err_mode;
    assign display_capture = load_edge.rise & ~err_mode;

    shift_stage #(.WIDTH(CHANNELS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (sclk_edge.rise),
        .retime_en  (sclk_edge.fall),
        .pload_en   (report_load),
        .ser_in     (ser_din),
        .pload_word (err_word),
        .shift_word (shift_word),
        .ser_out    (ser_dout)
    );

    display_latch #(.WIDTH(CHANNELS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (display_capture),
        .word_in (shift_word),
        .oe_n    (oe_n),
        .chan_on (chan_on)
    );

endmodule

// File: rtl/led_chain_slice_chk.sv
module led_chain_slice_chk #(
    parameter int CHANNELS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_clk,
    input logic                load_strobe,
    input logic                oe_n,
    input logic                err_mode,
    input logic                err_msb,
    input logic [CHANNELS-1:0] chan_on,
    input logic                ser_dout
);

    // Counts edges since reset so that $past never reaches into reset
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (chan_on == '0 && ser_dout == 1'b0));

    p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (chan_on == '0));

    p_dout_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && ser_dout != $past(ser_dout)) |->
        (($past(ser_clk) == 1'b0 && $past(ser_clk, 2) == 1'b1) ||
         ($past(err_mode) && !$past(load_strobe) && $past(load_strobe, 2))));

    p_report_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(err_mode) && !$past(load_strobe) && $past(load_strobe, 2))
        |-> (ser_dout == $past(err_msb)));

    // Covers R4 and R8: displayed data moves only on a display-mode rising load
    p_display_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !oe_n && !$past(oe_n) && chan_on != $past(chan_on)) |->
        ($past(load_strobe) && !$past(load_strobe, 2) && !$past(err_mode)));

endmodule

bind led_chain_slice led_chain_slice_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .load_strobe (load_strobe),
    .oe_n        (oe_n),
    .err_mode    (err_mode),
    .err_msb     (err_word[CHANNELS-1]),
    .chan_on     (chan_on),
    .ser_dout    (ser_dout)
);

// File: tb/test_led_chain_slice.sv
module test_led_chain_slice;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       sdi = 1'b0;
    logic       load_strobe = 1'b0;
    logic       oe_n = 1'b1;
    logic       err_mode = 1'b0;
    logic [7:0] err_w [3];
    logic [7:0] chan [3];
    logic [2:0] dout;
    logic [3:0] link;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign link[0] = sdi;

    for (genvar d = 0; d < 3; d++) begin : g_dev
        assign link[d+1] = dout[d];
        led_chain_slice #(.CHANNELS(8)) i_led_chain_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .ser_clk     (ser_clk),
            .ser_din     (link[d]),
            .load_strobe (load_strobe),
            .oe_n        (oe_n),
            .err_mode    (err_mode),
            .err_word    (err_w[d]),
            .chan_on     (chan[d]),
            .ser_dout    (dout[d])
        );
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer registers per device, chained by value
    int m_sr [3];
    int m_dat [3];
    int m_out [3];
    bit m_clk_prev;
    bit m_ld_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 3; d++) begin
                m_sr[d] = 0; m_dat[d] = 0; m_out[d] = 0;
            end
            m_clk_prev = 0;
            m_ld_prev  = 0;
        end else begin
            int  prev_out [3];
            bit  up, down, lup, ldown;
            int  din;
            prev_out = m_out;
            up    = ser_clk && !m_clk_prev;
            down  = !ser_clk && m_clk_prev;
            lup   = load_strobe && !m_ld_prev;
            ldown = !load_strobe && m_ld_prev;
            for (int d = 0; d < 3; d++) begin
                din = (d == 0) ? int'(sdi) : prev_out[d-1];
                if (lup && !err_mode) m_dat[d] = m_sr[d];
                if (err_mode && ldown) begin
                    m_sr[d]  = int'(err_w[d]);
                    m_out[d] = (int'(err_w[d]) >> 7) & 1;
                end else if (up) begin
                    m_sr[d] = ((m_sr[d] << 1) | din) & 255;
                end else if (down) begin
                    m_out[d] = (m_sr[d] >> 7) & 1;
                end
            end
            m_clk_prev = ser_clk;
            m_ld_prev  = load_strobe;
        end
    end

    always @(negedge clk) begin
        for (int d = 0; d < 3; d++) begin
            check("R5 model channels", chan[d], oe_n ? 0 : m_dat[d]);
            check("R3 model serial out", dout[d], m_out[d]);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic b, output logic [2:0] hi);
        sdi = b;
        step();
        ser_clk = 1'b1;
        step(); step();
        hi = dout;
        ser_clk = 1'b0;
        step(); step();
    endtask

    task automatic load_pulse();
        load_strobe = 1'b1;
        step(); step();
        load_strobe = 1'b0;
        step();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [2:0]  hi;
        logic [23:0] word;
        logic [23:0] got;
        logic [7:0]  got8;
        err_w[0] = 8'h00; err_w[1] = 8'h00; err_w[2] = 8'h00;
        repeat (3) step();
        check("R1 reset channels dev0", chan[0], 0);
        check("R1 reset serial out", dout, 0);
        rst_n = 1'b1;
        oe_n  = 1'b0;
        step();

        // R2 and R4: 24-bit display stream, first byte lands in the far device
        word = 24'hA53C81;
        for (int i = 23; i >= 0; i--) pulse(word[i], hi);
        check("R4 shift leaves display dev0", chan[0], 0);
        check("R3 serial out holds bit 7 dev0", dout[0], 1);
        check("R3 serial out holds bit 7 dev1", dout[1], 0);
        load_pulse();
        check("R2 R4 latched dev0", chan[0], 8'h81);
        check("R2 R4 latched dev1", chan[1], 8'h3C);
        check("R2 R4 latched dev2", chan[2], 8'hA5);

        // R3: output holds through the high phase, moves at the fall
        sdi = 1'b0;
        step();
        ser_clk = 1'b1;
        step(); step();
        check("R3 no change on rise dev0", dout[0], 1);
        ser_clk = 1'b0;
        step();
        check("R3 change on fall dev0", dout[0], 0);
        step();

        // R5: enable gating in both modes
        oe_n = 1'b1;
        step();
        check("R5 disabled dev2", chan[2], 0);
        err_mode = 1'b1;
        step();
        check("R5 disabled in report mode dev0", chan[0], 0);
        oe_n = 1'b0;
        step();
        check("R5 re-enabled dev2", chan[2], 8'hA5);

        // R6 and R8: report load, then report shifted through the chain
        err_w[0] = 8'h5A; err_w[1] = 8'hC3; err_w[2] = 8'h96;
        load_pulse();
        check("R6 report msb on load", dout, 3'b110);
        check("R8 report-mode rise keeps display dev1", chan[1], 8'h3C);
        got = '0;
        for (int i = 23; i >= 0; i--) begin
            pulse(1'b0, hi);
            got[i] = hi[2];
        end
        check("R6 report stream at chain end", got, 24'h96C35A);
        check("R8 display unchanged after report dev0", chan[0], 8'h81);

        // R9: display-mode falling load ignores the error word
        err_mode = 1'b0;
        err_w[0] = 8'hFF; err_w[1] = 8'hFF; err_w[2] = 8'hFF;
        word = 24'h0F7E33;
        for (int i = 23; i >= 0; i--) pulse(word[i], hi);
        load_pulse();
        check("R9 falling load ignored in display mode", dout, 3'b000);
        check("R4 second latch dev0", chan[0], 8'h33);
        check("R4 second latch dev2", chan[2], 8'h0F);
        pulse(1'b0, hi);
        check("R9 shift register kept data dev0", dout[0], 0);
        check("R9 shift register kept data dev1", dout[1], 1);

        // R7: load fall and serial rise in the same cycle
        err_mode = 1'b1;
        err_w[0] = 8'hB4;
        load_strobe = 1'b1;
        step(); step();
        load_strobe = 1'b0;
        ser_clk = 1'b1;
        sdi = 1'b1;
        step(); step();
        ser_clk = 1'b0;
        step(); step();
        check("R7 load wins over shift msb", dout[0], 1);
        got8 = '0;
        for (int i = 7; i >= 0; i--) begin
            pulse(1'b0, hi);
            got8[i] = hi[0];
        end
        check("R7 report intact after collision", got8, 8'hB4);
        check("R8 display kept through collision dev0", chan[0], 8'h33);

        step();
        finish_run();
    end

endmodule